// File: doc/BRIEF.md
# Byte-Register SPI Command Engine

This block is a SPI master for serial flash. A host talks to it through eight byte-wide I/O registers. The host first polls a busy flag until the engine is idle. It then loads a command byte, up to three address bytes and an optional trailing byte into their registers. A single write to the control register selects how many bytes go out and how many come back, and starts the transfer. The engine lowers chip select, clocks out the chosen bytes, clocks in up to three response bytes, and releases chip select. It clears busy one cycle later. The host can then read the response bytes from three result registers.

Only four outgoing lengths exist: one, two, four or five bytes. The address bytes sit in the registers in the reverse of their order on the wire. The highest address register goes out first. The SPI clock comes from the system clock through a divider with a fixed half period. Bus timing follows SPI mode 0, most significant bit first.

Top module: `spicmd_engine`

## Requirements
- R1: After reset, chip select is high, the SPI clock is low, offset 0 reads 0x00, and offsets 5, 6 and 7 read 0x00.
- R2: A host write to offset 0 starts a transfer when busy is clear and data bits 7:4 equal 0101. Offset 0 bit 7 (busy) then reads 1 from the clock edge that takes the write.
- R3: Control bits 1:0 choose the outgoing length: code 0 sends 1 byte, 1 sends 2, 2 sends 4 and 3 sends 5. Control bits 3:2 give the incoming byte count, 0 to 3. One transfer produces exactly 8 x (outgoing + incoming) rising SPI clock edges.
- R4: The byte order on the wire is fixed. The first byte is always offset 1. With code 1 the second byte is offset 7. With codes 2 and 3, offset 4, then offset 3, then offset 2 follow. Code 3 then adds offset 7 last.
- R5: The SPI clock idles low. MOSI is stable at every rising edge and carries each byte MSB first. MOSI is 0 for every bit of the incoming phase.
- R6: Incoming bytes appear in arrival order at offset 5 (first), offset 6 and offset 7. Result bytes beyond the requested count read 0x00 after the transfer.
- R7: Each SPI clock half period lasts HALF_DIV system clock cycles.
- R8: Chip select stays low without a break from the start write until after the last incoming bit. It is high for a full cycle before busy reads 0.
- R9: While busy is set, every host write is ignored. This covers a second start code on offset 0 and new data on offsets 1 to 4 and 7.
- R10: A write to offset 0 whose bits 7:4 differ from 0101 starts nothing. Chip select stays high and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register offset for host read and write |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_rdata | output | 8 | Read data for the register at host_addr |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check the framing rules on every cycle. These rules are: a valid start sets busy on the next edge, a bad start code leaves busy clear, chip select is never low without busy, chip select is released before busy drops, the clock is low whenever chip select is high, and MOSI never moves at a rising clock edge. Other properties need a whole transaction, so only the bench scenarios can show them. These are the per-code byte order with its reversed address bytes, the exact number of clock edges, where the result bytes land and the zeroing of unused ones, the half-period length, and the way writes are ignored while busy. A slave model in the bench captures each of these and compares it against values computed from the register contents.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
  localparam int BYTE_W   = 8;
  localparam int OFS_W    = 3;
  localparam int TX_BYTES = 5;
  localparam int RX_BYTES = 3;
  localparam int TX_W     = TX_BYTES * BYTE_W;
  localparam int RX_W     = RX_BYTES * BYTE_W;
  localparam int CNT_W    = $clog2(TX_W + RX_W + 1);
  localparam int BYTE_SH  = $clog2(BYTE_W);

  localparam logic [3:0]       START_KEY = 4'h5;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_RES0  = 3'd5;
  localparam logic [OFS_W-1:0] OFS_RES1  = 3'd6;
  localparam logic [OFS_W-1:0] OFS_TAIL  = 3'd7;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD, ST_DONE} seq_state_e;

  // outgoing byte count for a length code
  function automatic logic [2:0] wlen_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd5;
    endcase
  endfunction

  // register offset that backs each transmit slot
  function automatic logic [OFS_W-1:0] slot_ofs(input int g);
    case (g)
      0:       return 3'd1;
      1:       return 3'd2;
      2:       return 3'd3;
      3:       return 3'd4;
      default: return OFS_TAIL;
    endcase
  endfunction
endpackage

// File: rtl/spicmd_regs.sv
module spicmd_regs
  import spicmd_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [OFS_W-1:0]                 host_addr,
  input  logic [BYTE_W-1:0]                host_wdata,
  input  logic                             host_wr,
  input  logic                             busy,
  input  logic [RX_BYTES-1:0][BYTE_W-1:0]  rx_bytes,
  output logic [BYTE_W-1:0]                host_rdata,
  output logic                             start,
  output logic [1:0]                       wl_code,
  output logic [1:0]                       rd_cnt,
  output logic [TX_W-1:0]                  tx_frame
);
  logic              wr_ok;
  logic [BYTE_W-1:0] slot_q [TX_BYTES];

  assign wr_ok = host_wr && !busy;

  for (genvar g = 0; g < TX_BYTES; g++) begin : g_slot
    logic hit;
    assign hit = wr_ok && (host_addr == slot_ofs(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q[g] <= '0;
      else if (hit) slot_q[g] <= host_wdata;
    end
  end

  assign start    = wr_ok && (host_addr == OFS_CTRL) && (host_wdata[7:4] == START_KEY);
  assign wl_code  = host_wdata[1:0];
  assign rd_cnt   = host_wdata[3:2];

  // wire order: command, then address high..low (slots 3,2,1), then tail
  always_comb begin
    case (wl_code)
      2'd0:    tx_frame = {slot_q[0], {(TX_W-BYTE_W){1'b0}}};
      2'd1:    tx_frame = {slot_q[0], slot_q[4], {(TX_W-2*BYTE_W){1'b0}}};
      2'd2:    tx_frame = {slot_q[0], slot_q[3], slot_q[2], slot_q[1], {BYTE_W{1'b0}}};
      default: tx_frame = {slot_q[0], slot_q[3], slot_q[2], slot_q[1], slot_q[4]};
    endcase
  end

  always_comb begin
    case (host_addr)
      OFS_CTRL: host_rdata = {busy, {(BYTE_W-1){1'b0}}};
      3'd1:     host_rdata = slot_q[0];
      3'd2:     host_rdata = slot_q[1];
      3'd3:     host_rdata = slot_q[2];
      3'd4:     host_rdata = slot_q[3];
      OFS_RES0: host_rdata = rx_bytes[0];
      OFS_RES1: host_rdata = rx_bytes[1];
      default:  host_rdata = rx_bytes[2];
    endcase
  end
endmodule

// File: rtl/spicmd_tick.sv
module spicmd_tick #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en && (cnt_q == LAST);

  always_comb begin
    if (!en || tick) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spicmd_seq.sv
module spicmd_seq
  import spicmd_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             start,
  input  logic [1:0]                       wl_code,
  input  logic [1:0]                       rd_cnt,
  input  logic [TX_W-1:0]                  tx_frame,
  input  logic                             tick,
  input  logic                             miso,
  output logic                             busy,
  output logic                             run,
  output logic                             cs_n,
  output logic                             sck,
  output logic                             mosi,
  output logic [RX_BYTES-1:0][BYTE_W-1:0]  rx_bytes
);
  seq_state_e                       state_q, state_d;
  logic                             sck_q, sck_d, cs_n_q, cs_n_d;
  logic [TX_W-1:0]                  tx_q, tx_d;
  logic [CNT_W-1:0]                 bcnt_q, bcnt_d, wbits_q, wbits_d, tbits_q, tbits_d;
  logic [RX_BYTES-1:0][BYTE_W-1:0]  rx_q, rx_d;
  logic [CNT_W-1:0]                 rdiff;
  logic [1:0]                       ridx;

  assign rdiff = bcnt_q - wbits_q;
  assign ridx  = rdiff[BYTE_SH +: 2];

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    tx_d    = tx_q;
    bcnt_d  = bcnt_q;
    wbits_d = wbits_q;
    tbits_d = tbits_q;
    rx_d    = rx_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SHIFT;
        sck_d   = 1'b0;
        tx_d    = tx_frame;
        bcnt_d  = '0;
        wbits_d = CNT_W'(wlen_bytes(wl_code)) << BYTE_SH;
        tbits_d = (CNT_W'(wlen_bytes(wl_code)) + CNT_W'(rd_cnt)) << BYTE_SH;
        rx_d    = '0;
      end
      ST_SHIFT: if (tick) begin
        if (!sck_q) begin
          sck_d = 1'b1;
          if (bcnt_q >= wbits_q) rx_d[ridx] = {rx_q[ridx][BYTE_W-2:0], miso};
        end else begin
          sck_d = 1'b0;
          if (bcnt_q == tbits_q - 1'b1) begin
            state_d = ST_HOLD;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            tx_d   = tx_q << 1;
          end
        end
      end
      ST_HOLD: if (tick) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
    cs_n_d = (state_d == ST_IDLE) || (state_d == ST_DONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      tx_q    <= '0;
      bcnt_q  <= '0;
      wbits_q <= '0;
      tbits_q <= '0;
      rx_q    <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      tx_q    <= tx_d;
      bcnt_q  <= bcnt_d;
      wbits_q <= wbits_d;
      tbits_q <= tbits_d;
      rx_q    <= rx_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign run      = (state_q == ST_SHIFT) || (state_q == ST_HOLD);
  assign cs_n     = cs_n_q;
  assign sck      = sck_q;
  assign mosi     = tx_q[TX_W-1];
  assign rx_bytes = rx_q;
endmodule

// File: rtl/spicmd_engine.sv
module spicmd_engine
  import spicmd_pkg::*;
#(
  parameter int HALF_DIV = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic [7:0]  host_wdata,
  input  logic        host_wr,
  output logic [7:0]  host_rdata,
  output logic        spi_cs_n,
  output logic        spi_sck,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic                             busy, run, tick, start;
  logic [1:0]                       wl_code, rd_cnt;
  logic [TX_W-1:0]                  tx_frame;
  logic [RX_BYTES-1:0][BYTE_W-1:0]  rx_bytes;

  spicmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .busy(busy), .rx_bytes(rx_bytes), .host_rdata(host_rdata),
    .start(start), .wl_code(wl_code), .rd_cnt(rd_cnt), .tx_frame(tx_frame)
  );

  spicmd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
  );

  spicmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .wl_code(wl_code), .rd_cnt(rd_cnt),
    .tx_frame(tx_frame), .tick(tick), .miso(spi_miso), .busy(busy), .run(run),
    .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi), .rx_bytes(rx_bytes)
  );
endmodule

// File: rtl/spicmd_engine_chk.sv
module spicmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic [7:0] host_wdata,
  input logic       host_wr,
  input logic       busy,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd0 && host_wdata[7:4] == 4'h5 && !busy) |=> busy); // R2
  AST_BAD_KEY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd0 && host_wdata[7:4] != 4'h5 && !busy) |=> !busy); // R10
  AST_SELECT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy); // R8
  AST_RELEASE_BEFORE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(spi_cs_n)); // R8
  AST_SCK_LOW_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck); // R5
  AST_MOSI_HELD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi)); // R5
endmodule

bind spicmd_engine spicmd_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .busy(busy), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .spi_mosi(spi_mosi)
);

// File: tb/spicmd_engine_bench.sv
`timescale 1ns/1ps
module spicmd_engine_bench;
  localparam int HALF_DIV = 3;
  localparam real TCLK    = 5.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0;
  logic       host_wr = 1'b0;
  logic [7:0] host_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  spicmd_engine #(.HALF_DIV(HALF_DIV)) u_spicmd_engine (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rdata(host_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- slave model ----------------
  logic [63:0] s_resp = '0, s_sh = '0, s_cap = '0;
  int  s_rises = 0, cs_falls = 0, cs_rises = 0, per_bad = 0;
  real last_rise = 0.0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;

  always @(spi_cs_n or spi_sck) begin
    if (prev_cs && !spi_cs_n) begin
      cs_falls++; s_rises = 0; s_cap = '0; s_sh = s_resp; spi_miso = s_sh[63];
    end else if (!prev_cs && spi_cs_n) begin
      cs_rises++;
    end
    if (!spi_cs_n && spi_sck && !prev_sck) begin
      if (s_rises > 0 && ($realtime - last_rise) != 2.0 * HALF_DIV * TCLK) per_bad++;
      last_rise = $realtime;
      s_rises++; s_cap = {s_cap[62:0], spi_mosi};
    end else if (!spi_cs_n && !spi_sck && prev_sck) begin
      s_sh = s_sh << 1; spi_miso = s_sh[63];
    end
    prev_cs = spi_cs_n; prev_sck = spi_sck;
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a; #1; d = host_rdata;
  endtask

  function automatic int nbytes(input logic [1:0] c);
    case (c) 2'd0: return 1; 2'd1: return 2; 2'd2: return 4; default: return 5; endcase
  endfunction

  function automatic logic [39:0] wire_frame(input logic [1:0] c, input logic [7:0] cmd,
      input logic [7:0] a2, input logic [7:0] a3, input logic [7:0] a4, input logic [7:0] tl);
    case (c)
      2'd0: return {cmd, 32'h0};
      2'd1: return {cmd, tl, 24'h0};
      2'd2: return {cmd, a4, a3, a2, 8'h0};
      default: return {cmd, a4, a3, a2, tl};
    endcase
  endfunction

  task automatic wait_idle(output bit ok);
    logic [7:0] v;
    ok = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk); rd(3'd0, v);
      if (!v[7]) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_xfer(input logic [1:0] c, input logic [1:0] nr, input logic [7:0] cmd,
      input logic [7:0] a2, input logic [7:0] a3, input logic [7:0] a4, input logic [7:0] tl,
      input logic [23:0] resp, input bit disturb);
    logic [7:0] v;
    logic [63:0] exp_cap;
    int nw, tot, falls0;
    bit ok;
    nw  = nbytes(c);
    tot = 8 * (nw + int'(nr));
    wr(3'd1, cmd); wr(3'd2, a2); wr(3'd3, a3); wr(3'd4, a4); wr(3'd7, tl);
    s_resp = {resp, 40'h0} >> (8 * nw);
    falls0 = cs_falls;
    wr(3'd0, {4'h5, nr, c});
    rd(3'd0, v);
    chk(v[7] == 1'b1, "R2 busy after start", v, 8'h80);
    if (disturb) begin
      repeat (40) @(negedge clk);
      wr(3'd0, 8'h5C); wr(3'd1, ~cmd); wr(3'd7, ~tl);
    end
    wait_idle(ok);
    chk(ok, "R8 transfer finished", ok, 1);
    chk(spi_cs_n == 1'b1 && cs_rises == cs_falls, "R8 cs released before idle", spi_cs_n, 1);
    chk(cs_falls == falls0 + 1, "R8 single chip-select window", cs_falls - falls0, 1);
    chk(s_rises == tot, "R3 sck rising edge count", s_rises, tot);
    exp_cap = {wire_frame(c, cmd, a2, a3, a4, tl), 24'h0} >> (64 - tot);
    chk(s_cap == exp_cap, "R4 R5 mosi bit stream", s_cap, exp_cap);
    chk(per_bad == 0, "R7 sck period", per_bad, 0);
    for (int i = 0; i < 3; i++) begin
      logic [7:0] e;
      e = (i < int'(nr)) ? resp[23 - 8*i -: 8] : 8'h00;
      rd(3'(5 + i), v);
      chk(v == e, "R6 result byte", v, e);
    end
    if (disturb) begin
      rd(3'd1, v);
      chk(v == cmd, "R9 command reg unchanged by busy write", v, cmd);
      repeat (30) @(negedge clk);
      chk(cs_falls == falls0 + 1 && spi_cs_n, "R9 no restart from busy write", cs_falls - falls0, 1);
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [7:0] v;
    int f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins after reset", {spi_cs_n, spi_sck}, 2'b10);
    rd(3'd0, v); chk(v == 8'h00, "R1 status after reset", v, 0);
    for (int i = 5; i < 8; i++) begin
      rd(3'(i), v); chk(v == 8'h00, "R1 result reg after reset", v, 0);
    end
    // R10 bad start key
    f0 = cs_falls;
    wr(3'd0, 8'h3F);
    rd(3'd0, v); chk(v[7] == 1'b0, "R10 no busy on bad key", v, 0);
    repeat (20) @(negedge clk);
    chk(cs_falls == f0 && spi_cs_n, "R10 no transfer on bad key", cs_falls - f0, 0);
    // directed: each length code
    run_xfer(2'd0, 2'd3, 8'h9F, 8'h00, 8'h00, 8'h00, 8'h00, 24'hC2_20_17, 1'b0); // R3 R6
    run_xfer(2'd1, 2'd1, 8'h05, 8'h11, 8'h22, 8'h33, 8'hA5, 24'h80_00_00, 1'b0); // R4
    run_xfer(2'd2, 2'd2, 8'h03, 8'h01, 8'h02, 8'h03, 8'h44, 24'hFF_01_00, 1'b0); // R4
    run_xfer(2'd3, 2'd0, 8'h02, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 24'h12_34_56, 1'b0); // R4 R6 zeros
    run_xfer(2'd3, 2'd3, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 24'h00_FF_00, 1'b0); // R3 max
    // R9 writes during busy
    run_xfer(2'd3, 2'd3, 8'h0B, 8'h10, 8'h20, 8'h30, 8'h40, 24'h5A_A5_3C, 1'b1);
    // random
    for (int k = 0; k < 24; k++) begin
      run_xfer(2'($urandom % 4), 2'($urandom % 4), 8'($urandom), 8'($urandom), 8'($urandom),
               8'($urandom), 8'($urandom), 24'($urandom), 1'b0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule